// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out where an instruction operand lives for a 16/32-bit CISC core. The decoder presents an addressing-mode code, a 3-bit register number, the operand size, up to two extension words and the address of the first extension word. The unit also sees the eight data registers and the eight address registers as flat buses. It then reports one of two results. The first is a register selector, when the operand sits in a register. The second is a memory address, together with any address-register update that the mode causes and the number of extension words the mode used up.

The unit does no fetching and no memory access. A one-cycle `req_valid` pulse starts a computation. One clock later `out_valid` is high for one cycle, and all result fields are registered alongside it. Requests may arrive on back-to-back cycles. The stack register and the byte-alignment rule for its step are parameters.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset, `out_valid` and `out_wb_en` are 0 and `out_ext_count` is 0.
- R2: Mode codes 0 and 1 (data and address register direct) give `out_is_reg`=1 and `out_reg_sel` = {1 for address / 0 for data, register number}. They give no write-back and an extension count of 0.
- R3: Mode 2 (indirect) gives the selected address register's contents as `out_addr`, with no write-back and an extension count of 0.
- R4: Mode 3 (post-increment) gives the register's old value as `out_addr`. It writes back old value plus step to that register.
- R5: Mode 4 (pre-decrement) gives old value minus step as both `out_addr` and the write-back value.
- R6: Size code 0 (byte) gives a step of 1, code 1 (word) a step of 2, and code 2 (long) a step of 4. A byte step on register 7 is 2.
- R7: Mode 5 adds the first extension word, sign-extended from 16 bits, to the address register. Extension count is 1.
- R8: Mode 6 uses the brief word in the first extension word. It adds the sign-extended bits 7:0, plus an index register, to the address register. Bit 15 set picks an address register as index and clear picks a data register. Bits 14:12 give the index register number. Bit 11 clear sign-extends the index register's low 16 bits, and set uses all of it. Extension count is 1.
- R9: Mode 7 gives the first extension word sign-extended as the address, with count 1. Mode 8 gives {first word, second word} as the address, with count 2.
- R10: Mode 9 adds the sign-extended first extension word to the extension-word address `ext_pc`. Mode 10 applies the R8 brief-word rule with `ext_pc` as base. Both have count 1.
- R11: Mode 11 (immediate) gives `ext_pc` as the address and no write-back. Count is 2 for size long and 1 otherwise.
- R12: Every result appears on the clock edge after the `req_valid` cycle. `out_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a computation this cycle |
| req_mode | input | 4 | Addressing-mode code (0..11) |
| req_reg | input | 3 | Register number from the instruction |
| req_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| ext_word0 | input | 16 | First extension word |
| ext_word1 | input | 16 | Second extension word |
| ext_pc | input | 32 | Address of the first extension word |
| dreg_file | input | 256 | Data registers, register i at bits 32*i+31:32*i |
| areg_file | input | 256 | Address registers, same packing |
| out_valid | output | 1 | Result strobe, one cycle per request |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_reg_sel | output | 4 | Register selector: bit 3 address/data, bits 2:0 number |
| out_addr | output | 32 | Effective memory address |
| out_wb_en | output | 1 | Address register update required |
| out_wb_reg | output | 3 | Address register to update |
| out_wb_data | output | 32 | New value for that register |
| out_ext_count | output | 2 | Extension words consumed (0, 1 or 2) |

## Verification
Every result field comes from a single register stage. Each field is therefore due on the first rising edge after the cycle in which `req_valid` is high, and `out_valid` must fall one edge later. The bench drives a request on a falling edge and drops `req_valid` on the next falling edge. At that point it reads all result ports, halfway between the edge that loaded them and the edge that could next change them. On the falling edge after that, it confirms that the strobe has cleared.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

   typedef enum logic [3:0] {
      EA_DREG     = 4'd0,
      EA_AREG     = 4'd1,
      EA_IND      = 4'd2,
      EA_POSTINC  = 4'd3,
      EA_PREDEC   = 4'd4,
      EA_DISP     = 4'd5,
      EA_INDEX    = 4'd6,
      EA_ABS_W    = 4'd7,
      EA_ABS_L    = 4'd8,
      EA_PC_DISP  = 4'd9,
      EA_PC_INDEX = 4'd10,
      EA_IMM      = 4'd11
   } ea_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } ea_size_e;

   localparam int unsigned EA_NREG  = 8;
   localparam int unsigned EA_EXT_W = 16;

endpackage

// File: rtl/ea_step_calc.sv
module ea_step_calc #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned SP_REG        = 7,
   parameter bit          SP_BYTE_ALIGN = 1'b1
) (
   input  logic [1:0]        size,
   input  logic [2:0]        reg_num,
   output logic [ADDR_W-1:0] step
);
   import ea_gen_pkg::*;

   logic [ADDR_W-1:0] byte_step;

   generate
      if (SP_BYTE_ALIGN) begin : g_sp_align
         always_comb begin
            byte_step = ADDR_W'(1);
            if (reg_num == 3'(SP_REG)) byte_step = ADDR_W'(2);
         end
      end else begin : g_no_align
         logic unused_reg_num;
         assign unused_reg_num = &{1'b0, reg_num};
         assign byte_step = ADDR_W'(1);
      end
   endgenerate

   always_comb begin
      unique case (ea_size_e'(size))
         SZ_BYTE: step = byte_step;
         SZ_WORD: step = ADDR_W'(2);
         default: step = ADDR_W'(4);
      endcase
   end

endmodule

// File: rtl/ea_index_calc.sv
module ea_index_calc #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [15:0]                              brief,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]    dreg_file,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]    areg_file,
   output logic [ADDR_W-1:0]                        offset
);
   logic              idx_is_addr;
   logic [2:0]        idx_num;
   logic              idx_is_long;
   logic [7:0]        disp8;
   logic [ADDR_W-1:0] idx_raw;
   logic [ADDR_W-1:0] idx_val;
   logic [ADDR_W-1:0] disp_ext;
   logic              unused_brief;

   assign idx_is_addr  = brief[15];
   assign idx_num      = brief[14:12];
   assign idx_is_long  = brief[11];
   assign disp8        = brief[7:0];
   assign unused_brief = &{1'b0, brief[10:8]};

   assign idx_raw  = idx_is_addr ? areg_file[idx_num*ADDR_W +: ADDR_W]
                                 : dreg_file[idx_num*ADDR_W +: ADDR_W];
   assign idx_val  = idx_is_long ? idx_raw
                                 : {{(ADDR_W-16){idx_raw[15]}}, idx_raw[15:0]};
   assign disp_ext = {{(ADDR_W-8){disp8[7]}}, disp8};
   assign offset   = idx_val + disp_ext;

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned SP_REG        = 7,
   parameter bit          SP_BYTE_ALIGN = 1'b1
) (
   input  logic [3:0]                             mode,
   input  logic [2:0]                             reg_num,
   input  logic [1:0]                             size,
   input  logic [15:0]                            ext0,
   input  logic [15:0]                            ext1,
   input  logic [ADDR_W-1:0]                      pc,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]  dreg_file,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]  areg_file,
   output logic                                   is_reg,
   output logic [3:0]                             reg_sel,
   output logic [ADDR_W-1:0]                      addr,
   output logic                                   wb_en,
   output logic [ADDR_W-1:0]                      wb_data,
   output logic [1:0]                             ext_count
);
   import ea_gen_pkg::*;

   logic [ADDR_W-1:0] base_a;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] idx_off;
   logic [ADDR_W-1:0] disp16;
   logic [ADDR_W-1:0] dec_val;
   ea_mode_e          m;

   assign m       = ea_mode_e'(mode);
   assign base_a  = areg_file[reg_num*ADDR_W +: ADDR_W];
   assign disp16  = {{(ADDR_W-16){ext0[15]}}, ext0};
   assign dec_val = base_a - step;
   assign reg_sel = {m == EA_AREG, reg_num};

   ea_step_calc #(
      .ADDR_W       (ADDR_W),
      .SP_REG       (SP_REG),
      .SP_BYTE_ALIGN(SP_BYTE_ALIGN)
   ) i_step (
      .size   (size),
      .reg_num(reg_num),
      .step   (step)
   );

   ea_index_calc #(
      .ADDR_W(ADDR_W)
   ) i_index (
      .brief    (ext0),
      .dreg_file(dreg_file),
      .areg_file(areg_file),
      .offset   (idx_off)
   );

   always_comb begin
      is_reg    = 1'b0;
      addr      = '0;
      wb_en     = 1'b0;
      wb_data   = '0;
      ext_count = 2'd0;
      unique case (m)
         EA_DREG, EA_AREG: is_reg = 1'b1;
         EA_IND:           addr   = base_a;
         EA_POSTINC: begin
            addr    = base_a;
            wb_en   = 1'b1;
            wb_data = base_a + step;
         end
         EA_PREDEC: begin
            addr    = dec_val;
            wb_en   = 1'b1;
            wb_data = dec_val;
         end
         EA_DISP: begin
            addr      = base_a + disp16;
            ext_count = 2'd1;
         end
         EA_INDEX: begin
            addr      = base_a + idx_off;
            ext_count = 2'd1;
         end
         EA_ABS_W: begin
            addr      = disp16;
            ext_count = 2'd1;
         end
         EA_ABS_L: begin
            addr      = ADDR_W'({ext0, ext1});
            ext_count = 2'd2;
         end
         EA_PC_DISP: begin
            addr      = pc + disp16;
            ext_count = 2'd1;
         end
         EA_PC_INDEX: begin
            addr      = pc + idx_off;
            ext_count = 2'd1;
         end
         EA_IMM: begin
            addr      = pc;
            ext_count = (ea_size_e'(size) == SZ_LONG) ? 2'd2 : 2'd1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned SP_REG        = 7,
   parameter bit          SP_BYTE_ALIGN = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [3:0]                             req_mode,
   input  logic [2:0]                             req_reg,
   input  logic [1:0]                             req_size,
   input  logic [15:0]                            ext_word0,
   input  logic [15:0]                            ext_word1,
   input  logic [ADDR_W-1:0]                      ext_pc,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]  dreg_file,
   input  logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]  areg_file,
   output logic                                   out_valid,
   output logic                                   out_is_reg,
   output logic [3:0]                             out_reg_sel,
   output logic [ADDR_W-1:0]                      out_addr,
   output logic                                   out_wb_en,
   output logic [2:0]                             out_wb_reg,
   output logic [ADDR_W-1:0]                      out_wb_data,
   output logic [1:0]                             out_ext_count
);
   generate
      if (ADDR_W < 32) begin : g_bad_addr_w
         $error("ea_gen_unit: ADDR_W must be at least 32");
      end
      if (SP_REG >= ea_gen_pkg::EA_NREG) begin : g_bad_sp_reg
         $error("ea_gen_unit: SP_REG out of register range");
      end
   endgenerate

   logic              c_is_reg;
   logic [3:0]        c_reg_sel;
   logic [ADDR_W-1:0] c_addr;
   logic              c_wb_en;
   logic [ADDR_W-1:0] c_wb_data;
   logic [1:0]        c_ext_count;

   ea_addr_calc #(
      .ADDR_W       (ADDR_W),
      .SP_REG       (SP_REG),
      .SP_BYTE_ALIGN(SP_BYTE_ALIGN)
   ) i_calc (
      .mode     (req_mode),
      .reg_num  (req_reg),
      .size     (req_size),
      .ext0     (ext_word0),
      .ext1     (ext_word1),
      .pc       (ext_pc),
      .dreg_file(dreg_file),
      .areg_file(areg_file),
      .is_reg   (c_is_reg),
      .reg_sel  (c_reg_sel),
      .addr     (c_addr),
      .wb_en    (c_wb_en),
      .wb_data  (c_wb_data),
      .ext_count(c_ext_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_is_reg    <= 1'b0;
         out_reg_sel   <= '0;
         out_addr      <= '0;
         out_wb_en     <= 1'b0;
         out_wb_reg    <= '0;
         out_wb_data   <= '0;
         out_ext_count <= '0;
      end else begin
         out_valid <= req_valid;
         out_wb_en <= req_valid & c_wb_en;
         if (req_valid) begin
            out_is_reg    <= c_is_reg;
            out_reg_sel   <= c_reg_sel;
            out_addr      <= c_addr;
            out_wb_reg    <= req_reg;
            out_wb_data   <= c_wb_data;
            out_ext_count <= c_ext_count;
         end
      end
   end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic                                   req_valid,
   input logic [3:0]                             req_mode,
   input logic [2:0]                             req_reg,
   input logic [ea_gen_pkg::EA_NREG*ADDR_W-1:0]  areg_file,
   input logic                                   out_valid,
   input logic                                   out_is_reg,
   input logic [ADDR_W-1:0]                      out_addr,
   input logic                                   out_wb_en,
   input logic [ADDR_W-1:0]                      out_wb_data,
   input logic [1:0]                             out_ext_count
);
   import ea_gen_pkg::*;

   logic [ADDR_W-1:0] sel_areg;
   assign sel_areg = areg_file[req_reg*ADDR_W +: ADDR_W];

   a_r12_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   a_r12_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(req_valid));

   a_r1_wb_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_wb_en |-> out_valid);

   a_r2_reg_direct_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_reg) |-> (out_ext_count == 2'd0 && !out_wb_en));

   a_r4_postinc_old_value: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == EA_POSTINC) |=>
         (out_addr == $past(sel_areg) && out_wb_en && out_wb_data != out_addr));

   a_r5_predec_addr_is_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == EA_PREDEC) |=> (out_wb_en && out_addr == out_wb_data));

   a_r11_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_ext_count != 2'd3);

endmodule

bind ea_gen_unit ea_gen_chk #(.ADDR_W(ADDR_W)) i_ea_gen_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_mode     (req_mode),
   .req_reg      (req_reg),
   .areg_file    (areg_file),
   .out_valid    (out_valid),
   .out_is_reg   (out_is_reg),
   .out_addr     (out_addr),
   .out_wb_en    (out_wb_en),
   .out_wb_data  (out_wb_data),
   .out_ext_count(out_ext_count)
);

// File: tb/test_ea_gen_unit.sv
`timescale 1ns/1ps
module test_ea_gen_unit;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_mode = '0;
   logic [2:0]    req_reg = '0;
   logic [1:0]    req_size = '0;
   logic [15:0]   ext_word0 = '0;
   logic [15:0]   ext_word1 = '0;
   logic [AW-1:0] ext_pc = 32'h0000_1000;
   logic [8*AW-1:0] dreg_file;
   logic [8*AW-1:0] areg_file;
   logic          out_valid, out_is_reg, out_wb_en;
   logic [3:0]    out_reg_sel;
   logic [AW-1:0] out_addr, out_wb_data;
   logic [2:0]    out_wb_reg;
   logic [1:0]    out_ext_count;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   ea_gen_unit i_ea_gen_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_reg(req_reg), .req_size(req_size), .ext_word0(ext_word0),
      .ext_word1(ext_word1), .ext_pc(ext_pc), .dreg_file(dreg_file),
      .areg_file(areg_file), .out_valid(out_valid), .out_is_reg(out_is_reg),
      .out_reg_sel(out_reg_sel), .out_addr(out_addr), .out_wb_en(out_wb_en),
      .out_wb_reg(out_wb_reg), .out_wb_data(out_wb_data),
      .out_ext_count(out_ext_count)
   );

   function automatic logic [AW-1:0] areg(input int i);
      return 32'h0002_0000 + 32'(i) * 32'h100;
   endfunction

   function automatic logic [AW-1:0] dreg(input int i);
      if (i == 5) return 32'h1234_FFF0;
      return 32'h0001_0000 * 32'(i) + 32'h40;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one request; returns at the falling edge after the loading edge
   task automatic issue(input logic [3:0] m, input logic [2:0] r, input logic [1:0] s,
                        input logic [15:0] e0, input logic [15:0] e1);
      @(negedge clk);
      req_mode = m; req_reg = r; req_size = s; ext_word0 = e0; ext_word1 = e1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R12", "out_valid", 32'(out_valid), 32'd1);
   endtask

   task automatic expect_mem(input string req, input logic [AW-1:0] a,
                             input logic wb, input logic [AW-1:0] wbd,
                             input logic [1:0] cnt);
      check(req, "is_reg", 32'(out_is_reg), 32'd0);
      check(req, "addr", out_addr, a);
      check(req, "wb_en", 32'(out_wb_en), 32'(wb));
      if (wb) begin
         check(req, "wb_data", out_wb_data, wbd);
         check(req, "wb_reg", 32'(out_wb_reg), 32'(req_reg));
      end
      check(req, "ext_count", 32'(out_ext_count), 32'(cnt));
   endtask

   task automatic t_reset();
      check("R1", "out_valid", 32'(out_valid), 32'd0);
      check("R1", "wb_en", 32'(out_wb_en), 32'd0);
      check("R1", "ext_count", 32'(out_ext_count), 32'd0);
   endtask

   task automatic t_reg_direct();
      issue(4'd0, 3'd3, 2'd2, 16'h0, 16'h0);
      check("R2", "is_reg", 32'(out_is_reg), 32'd1);
      check("R2", "sel data", 32'(out_reg_sel), 32'h3);
      check("R2", "wb_en", 32'(out_wb_en), 32'd0);
      check("R2", "ext", 32'(out_ext_count), 32'd0);
      issue(4'd1, 3'd5, 2'd1, 16'h0, 16'h0);
      check("R2", "sel addr", 32'(out_reg_sel), 32'hD);
      @(negedge clk);
      check("R12", "strobe cleared", 32'(out_valid), 32'd0);
   endtask

   task automatic t_indirect();
      issue(4'd2, 3'd2, 2'd1, 16'h0, 16'h0);
      expect_mem("R3", areg(2), 1'b0, '0, 2'd0);
   endtask

   task automatic t_postinc();
      issue(4'd3, 3'd2, 2'd2, 16'h0, 16'h0);
      expect_mem("R4", areg(2), 1'b1, areg(2) + 4, 2'd0);
      issue(4'd3, 3'd1, 2'd1, 16'h0, 16'h0);
      expect_mem("R6", areg(1), 1'b1, areg(1) + 2, 2'd0);
      issue(4'd3, 3'd7, 2'd0, 16'h0, 16'h0);
      expect_mem("R6", areg(7), 1'b1, areg(7) + 2, 2'd0);
      issue(4'd3, 3'd4, 2'd0, 16'h0, 16'h0);
      expect_mem("R6", areg(4), 1'b1, areg(4) + 1, 2'd0);
   endtask

   task automatic t_predec();
      issue(4'd4, 3'd3, 2'd2, 16'h0, 16'h0);
      expect_mem("R5", areg(3) - 4, 1'b1, areg(3) - 4, 2'd0);
      issue(4'd4, 3'd7, 2'd0, 16'h0, 16'h0);
      expect_mem("R6", areg(7) - 2, 1'b1, areg(7) - 2, 2'd0);
      issue(4'd4, 3'd0, 2'd0, 16'h0, 16'h0);
      expect_mem("R6", areg(0) - 1, 1'b1, areg(0) - 1, 2'd0);
   endtask

   task automatic t_disp();
      issue(4'd5, 3'd1, 2'd1, 16'hFF00, 16'h0);
      expect_mem("R7", areg(1) - 256, 1'b0, '0, 2'd1);
      issue(4'd5, 3'd1, 2'd1, 16'h0010, 16'h0);
      expect_mem("R7", areg(1) + 16, 1'b0, '0, 2'd1);
   endtask

   task automatic t_index();
      issue(4'd6, 3'd2, 2'd1, 16'h50FC, 16'h0);   // d5 word, disp -4
      expect_mem("R8", areg(2) - 16 - 4, 1'b0, '0, 2'd1);
      issue(4'd6, 3'd2, 2'd1, 16'h58FC, 16'h0);   // d5 long
      expect_mem("R8", areg(2) + 32'h1234_FFF0 - 4, 1'b0, '0, 2'd1);
      issue(4'd6, 3'd2, 2'd1, 16'hE004, 16'h0);   // a6 word, disp +4
      expect_mem("R8", areg(2) + 32'h0600 + 4, 1'b0, '0, 2'd1);
   endtask

   task automatic t_abs();
      issue(4'd7, 3'd0, 2'd1, 16'h8000, 16'h0);
      expect_mem("R9", 32'hFFFF_8000, 1'b0, '0, 2'd1);
      issue(4'd7, 3'd0, 2'd1, 16'h1234, 16'h0);
      expect_mem("R9", 32'h0000_1234, 1'b0, '0, 2'd1);
      issue(4'd8, 3'd0, 2'd1, 16'h00AB, 16'hCDEF);
      expect_mem("R9", 32'h00AB_CDEF, 1'b0, '0, 2'd2);
   endtask

   task automatic t_pc();
      issue(4'd9, 3'd0, 2'd1, 16'hFFFE, 16'h0);
      expect_mem("R10", 32'h0000_0FFE, 1'b0, '0, 2'd1);
      issue(4'd10, 3'd0, 2'd1, 16'h3002, 16'h0);  // d3 word, disp +2
      expect_mem("R10", 32'h0000_1042, 1'b0, '0, 2'd1);
   endtask

   task automatic t_imm();
      issue(4'd11, 3'd0, 2'd1, 16'h0, 16'h0);
      expect_mem("R11", 32'h0000_1000, 1'b0, '0, 2'd1);
      issue(4'd11, 3'd0, 2'd2, 16'h0, 16'h0);
      expect_mem("R11", 32'h0000_1000, 1'b0, '0, 2'd2);
      issue(4'd11, 3'd0, 2'd0, 16'h0, 16'h0);
      expect_mem("R11", 32'h0000_1000, 1'b0, '0, 2'd1);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      req_mode = 4'd2; req_reg = 3'd1; req_valid = 1'b1;
      @(negedge clk);
      check("R12", "first addr", out_addr, areg(1));
      req_reg = 3'd6;
      @(negedge clk);
      req_valid = 1'b0;
      check("R12", "second valid", 32'(out_valid), 32'd1);
      check("R12", "second addr", out_addr, areg(6));
      @(negedge clk);
      check("R12", "valid drops", 32'(out_valid), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         areg_file[i*AW +: AW] = areg(i);
         dreg_file[i*AW +: AW] = dreg(i);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_reg_direct();
      t_indirect();
      t_postinc();
      t_predec();
      t_disp();
      t_index();
      t_abs();
      t_pc();
      t_imm();
      t_back_to_back();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule